// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block takes four raw interrupt request pins from outside the chip and turns each one into a qualified request for a downstream interrupt encoder. Each pin is first passed through a synchroniser. It is then interpreted according to a sense mode chosen at run time: active-high level, rising edge, falling edge or active-low level. All per-line settings live in a single 32-bit control word. That word also carries a master external enable and a critical-routing selection, which is brought out as a port.

In the two edge modes, a detected edge sets a sticky pending flag. The flag stays set until software writes a one to the line's clear bit. Each line is tracked by a two-state machine. `LN_QUIET` moves to `LN_PENDING` on a detected edge of the selected polarity. `LN_PENDING` returns to `LN_QUIET` when a clear is written and no new edge arrives in that same cycle. In the two level modes, the synchronised level is passed straight through, and the pending flag plays no part in the request.

Software may rewrite the control word at any time. Bits 23:16 hold the sense configuration, so a write that keeps those bits leaves every line's sense unchanged.

Top module: `extirq_cond`

## Requirements
- R1: The writable bits are the sense field of line n at bits [23-2n:22-2n], the enable of line n at bit 11-n, the master enable at bit 12 and the routing bit at bit 0. Reading the control word returns exactly these bits, and every other bit reads as zero. The word changes only on a write.
- R2: Bits 27-n always read as zero. Writing a one to bit 27-n returns line n's pending flag to quiet. Writing a zero there leaves the flag unchanged.
- R3: In sense code 0 (active-high level), the request follows the synchronised pin level, with no latching.
- R4: In sense code 1 (rising edge), a low-to-high transition of the pin sets a sticky pending flag. The flag holds the request after the pin falls again.
- R5: In sense code 2 (falling edge), a high-to-low transition sets the sticky pending flag. A rising transition does not set it.
- R6: In sense code 3 (active-low level), the request is the inverse of the synchronised pin level.
- R7: The request of line n is asserted only when enable bit 11-n and master bit 12 are both one.
- R8: The pending flag captures an edge while the line is disabled, and the request appears once the line is enabled.
- R9: In level modes, a pin change reaches the request output after 2 clock edges. In edge modes, it reaches the output after 3 clock edges.
- R10: When an edge is detected in the same cycle as a clear of that line, the flag ends up pending.
- R11: After reset, the control word reads as zero, all requests are low and the routing output is low. Every line is therefore disabled and in active-high level sense.
- R12: The routing output `crit_route_o` equals control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data for the control word |
| rd_data | output | 32 | Current control word |
| irq_pin | input | 4 | Raw asynchronous interrupt pins, line n on bit n |
| irq_req | output | 4 | Qualified request per line |
| crit_route_o | output | 1 | Critical routing selection |

## Verification
A pending flag stuck in the wrong state shows at `irq_req` as soon as its line is enabled. A flag that fails to set shows within three clocks of an edge, and a flag that fails to clear shows on the cycle after the clear write. A wrong sense decode or a misplaced field shows up in the full sweep of every line against every mode, because only the addressed line may respond, and only with the polarity its mode implies. Errors in synchroniser depth or edge-tap timing appear as a one-cycle shift in the exact latency checks. An inverted priority between set and clear is exposed by a clear that coincides with an edge.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int NUM_LINES  = 4;
    localparam int CTRL_W     = 32;
    localparam int MASTER_BIT = 12;
    localparam int ROUTE_BIT  = 0;

    typedef enum logic [1:0] {
        SENSE_LVL_HI = 2'd0,
        SENSE_RISE   = 2'd1,
        SENSE_FALL   = 2'd2,
        SENSE_LVL_LO = 2'd3
    } sense_e;

    typedef enum logic {
        LN_QUIET   = 1'b0,
        LN_PENDING = 1'b1
    } line_state_e;

    function automatic int sense_lsb(input int n);
        return 22 - 2 * n;
    endfunction

    function automatic int en_bit(input int n);
        return 11 - n;
    endfunction

    function automatic int clr_bit(input int n);
        return 27 - n;
    endfunction

    function automatic logic [CTRL_W-1:0] writable_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        m[MASTER_BIT] = 1'b1;
        m[ROUTE_BIT]  = 1'b1;
        for (int n = 0; n < NUM_LINES; n++) begin
            m[en_bit(n)]        = 1'b1;
            m[sense_lsb(n)]     = 1'b1;
            m[sense_lsb(n) + 1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_line.sv
module extirq_line
    import extirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lvl_i,
    input  sense_e sense_i,
    input  logic   en_i,
    input  logic   clr_i,
    output logic   req_o
);
    logic        prev_q;
    logic        hit;
    logic        is_edge;
    logic        raw;
    line_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
        end
    end

    always_comb begin
        is_edge = (sense_i == SENSE_RISE) || (sense_i == SENSE_FALL);
        hit     = ((sense_i == SENSE_RISE) &&  lvl_i && !prev_q) ||
                  ((sense_i == SENSE_FALL) && !lvl_i &&  prev_q);
    end

    // next-state logic: a detected edge outranks a clear
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LN_QUIET:   st_d = hit ? LN_PENDING : LN_QUIET;
            LN_PENDING: st_d = (clr_i && !hit) ? LN_QUIET : LN_PENDING;
            default:    st_d = LN_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= LN_QUIET;
        end else begin
            st_q <= st_d;
        end
    end

    // output logic
    always_comb begin
        unique case (sense_i)
            SENSE_LVL_HI: raw = lvl_i;
            SENSE_LVL_LO: raw = !lvl_i;
            default:      raw = (st_q == LN_PENDING);
        endcase
        req_o = raw && en_i;
    end

    // R4
    pending_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LN_PENDING && !clr_i) |=> (st_q == LN_PENDING));

    // R2
    clear_in_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !is_edge) |=> (st_q == LN_QUIET));

    // R5
    set_needs_edge_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == LN_PENDING) |-> $past(is_edge));
endmodule

// File: rtl/extirq_cond.sv
module extirq_cond
    import extirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CTRL_W-1:0]    wr_data,
    output logic [CTRL_W-1:0]    rd_data,
    input  logic [NUM_LINES-1:0] irq_pin,
    output logic [NUM_LINES-1:0] irq_req,
    output logic                 crit_route_o
);
    localparam logic [CTRL_W-1:0] WR_MASK = writable_mask();

    logic [CTRL_W-1:0]    ctrl_q;
    logic [NUM_LINES-1:0] pin_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data & WR_MASK;
        end
    end

    assign rd_data      = ctrl_q;
    assign crit_route_o = ctrl_q[ROUTE_BIT];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (irq_pin[i]),
            .q_o   (pin_s[i])
        );

        extirq_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_i   (pin_s[i]),
            .sense_i (sense_e'(ctrl_q[sense_lsb(i) +: 2])),
            .en_i    (ctrl_q[en_bit(i)] && ctrl_q[MASTER_BIT]),
            .clr_i   (wr_en && wr_data[clr_bit(i)]),
            .req_o   (irq_req[i])
        );

        // R7
        req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[i] |-> (rd_data[en_bit(i)] && rd_data[MASTER_BIT]));
    end

    // R1
    ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));
endmodule

// File: tb/sim_extirq_cond.sv
module sim_extirq_cond;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq_pin = '0;
    logic [3:0]  irq_req;
    logic        crit_route_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    extirq_cond u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_pin(irq_pin), .irq_req(irq_req),
        .crit_route_o(crit_route_o)
    );

    localparam logic [31:0] MASK = 32'h00FF_1F01;
    localparam logic [31:0] MSTR = 32'h0000_1000;
    localparam logic [31:0] CLRA = 32'h0F00_0000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic logic [31:0] cfg(input int n, input int m, input bit en);
        return MSTR | (en ? (32'd1 << (11 - n)) : 32'd0) | (32'(m) << (22 - 2 * n));
    endfunction

    function automatic bit model(input int m, input bit p, input bit lat);
        case (m)
            0: return p;
            3: return !p;
            default: return lat;
        endcase
    endfunction

    initial begin
        string tg[4] = '{"R3", "R4", "R5", "R6"};
        logic [31:0] c;
        bit lat;

        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", rd_data, 32'h0);
        chk("R11", {28'h0, irq_req}, 32'h0);
        chk("R11", {31'h0, crit_route_o}, 32'h0);

        // R1: writable bit map and read-back
        wr(32'hFFFF_FFFF);
        chk("R1", rd_data, MASK);
        chk("R12", {31'h0, crit_route_o}, 32'h1);
        wr(32'h0);
        chk("R12", {31'h0, crit_route_o}, 32'h0);

        // full sweep: every line against every sense mode
        for (int n = 0; n < 4; n++) begin
            for (int m = 0; m < 4; m++) begin
                c = cfg(n, m, 1'b1);
                wr(c | CLRA);
                idle(4);
                lat = 1'b0;
                chk(tg[m], {28'h0, irq_req}, 32'(model(m, 1'b0, lat)) << n);
                chk("R1", rd_data, c & MASK);
                irq_pin[n] = 1'b1;
                idle(4);
                lat = (m == 1);
                chk(tg[m], {28'h0, irq_req}, 32'(model(m, 1'b1, lat)) << n);
                irq_pin[n] = 1'b0;
                idle(4);
                lat = lat | (m == 2);
                chk(tg[m], {28'h0, irq_req}, 32'(model(m, 1'b0, lat)) << n);
                // R2: zero in own clear bit leaves the latch alone
                wr(c | (CLRA & ~(32'd1 << (27 - n))));
                chk("R2", {28'h0, irq_req}, 32'(model(m, 1'b0, lat)) << n);
                chk("R2", rd_data & CLRA, 32'h0);
                // R2: one in own clear bit empties the latch
                wr(c | (32'd1 << (27 - n)));
                lat = 1'b0;
                chk("R2", {28'h0, irq_req}, 32'(model(m, 1'b0, lat)) << n);
            end
        end

        // R9: level latency is 2 edges
        wr(cfg(0, 0, 1'b1) | CLRA);
        idle(4);
        irq_pin[0] = 1'b1;
        @(negedge clk);
        chk("R9", {28'h0, irq_req}, 32'h0);
        @(negedge clk);
        chk("R9", {28'h0, irq_req}, 32'h1);
        irq_pin[0] = 1'b0;
        idle(4);

        // R9: edge latency is 3 edges
        wr(cfg(0, 1, 1'b1) | CLRA);
        idle(4);
        irq_pin[0] = 1'b1;
        @(negedge clk);
        chk("R9", {28'h0, irq_req}, 32'h0);
        @(negedge clk);
        chk("R9", {28'h0, irq_req}, 32'h0);
        @(negedge clk);
        chk("R9", {28'h0, irq_req}, 32'h1);
        irq_pin[0] = 1'b0;
        idle(4);

        // R10: edge coincides with a clear; set wins
        wr(cfg(0, 1, 1'b1) | CLRA);
        idle(4);
        chk("R10", {28'h0, irq_req}, 32'h0);
        irq_pin[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = cfg(0, 1, 1'b1) | 32'h0800_0000;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        chk("R10", {28'h0, irq_req}, 32'h1);
        irq_pin[0] = 1'b0;
        idle(4);

        // R7 / R8: capture while disabled, then gate by enable and master
        wr(cfg(1, 1, 1'b0) | CLRA);
        idle(4);
        irq_pin[1] = 1'b1;
        idle(4);
        chk("R7", {28'h0, irq_req}, 32'h0);
        wr(cfg(1, 1, 1'b1));
        chk("R8", {28'h0, irq_req}, 32'h2);
        wr(cfg(1, 1, 1'b1) & ~MSTR);
        chk("R7", {28'h0, irq_req}, 32'h0);
        wr(cfg(1, 1, 1'b1));
        chk("R7", {28'h0, irq_req}, 32'h2);
        irq_pin[1] = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule